// File: doc/BRIEF.md
# Push-Pull PWM Generator with Soft Start

This block produces the two drive signals for a half-bridge stage coupled through a pulse transformer. A free-running up-counter forms a digital sawtooth. Within each sawtooth period the counter is compared against a control threshold, which is the larger of the sampled error word and an internal soft-start value. When the counter is above that threshold, one of the two outputs conducts. A toggle stage flips once after every period that had a conducting window. The toggle state steers pulses to `drv_a` and `drv_b` in turn, so each output is active on at most every other period.

A higher error word gives a narrower pulse. The soft-start value begins at full scale, so the block starts at zero duty. It then steps down by one count every `SS_STEP` periods until it reaches a floor, and that floor is set by the dead-time limit word. When the limit word is at full scale, the maximum width is just under half of each output's cycle. A fault input, or removal of enable, turns both outputs off at once and sends the soft start back to full scale.

Top module: `pp_pwm_gen`

## Requirements
- R1: While `rst_n` is low, `drv_a` and `drv_b` are both low, and the soft-start value is held at full scale.
- R2: The sawtooth period is 2^CNT_W clock cycles. In a period with threshold T = max(sampled error word, soft-start value), the active output is high for exactly (2^CNT_W - 1) - T cycles, and those cycles are the last ones of the period. A T at full scale gives no pulse.
- R3: Successive pulses go to `drv_a` and `drv_b` in turn, and the two outputs are never high in the same cycle.
- R4: Every pulse ends at the period wrap and is never longer than 2^CNT_W - 1 cycles. Each output's duty therefore stays below 50%.
- R5: The soft-start floor is (2^CNT_W - 1) - `dt_limit`. In steady state the pulse width is min(`dt_limit`, (2^CNT_W - 1) - error word).
- R6: When the block starts running (enable high and fault low), the first period has no pulse. The soft-start value then drops by one every SS_STEP period wraps, so pulse widths start at 1 and never decrease until the floor is reached.
- R7: If the floor rises above the current soft-start value, the soft-start value jumps to the floor at the next wrap.
- R8: While `fault` is high, both outputs are low in that same cycle. Once `fault` is released, a fresh soft start runs from full scale.
- R9: While `en` is low, both outputs are low. Raising `en` again starts a fresh soft start from full scale.
- R10: `err_word` and `dt_limit` are captured only at the period wrap. A change in the middle of a period first takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low stops output and rearms soft start |
| fault | input | 1 | Protection input; high forces both outputs off |
| err_word | input | CNT_W | Digital error value; higher means narrower pulses |
| dt_limit | input | CNT_W | Maximum pulse width in counts |
| drv_a | output | 1 | Drive for the first transformer phase, active high |
| drv_b | output | 1 | Drive for the second transformer phase, active high |

## Verification
The assertions assume that `en` and `fault` are synchronous to `clk` and that they stay stable across each rising edge. The outputs follow these two inputs through logic with no register in between. The stimulus respects this by changing every input just after a rising edge and sampling the outputs on the falling edge. The error and limit words are allowed to change at any point in a period, including in the middle of a pulse, which tests the wrap-only capture.

// File: rtl/pp_pwm_gen.sv
module pp_pwm_gen #(
  parameter int CNT_W   = 8,
  parameter int SS_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fault,
  input  logic [CNT_W-1:0] err_word,
  input  logic [CNT_W-1:0] dt_limit,
  output logic             drv_a,
  output logic             drv_b
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam int STEP_W = (SS_STEP > 1) ? $clog2(SS_STEP) : 1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SS_STEP - 1);

  logic [CNT_W-1:0]  cnt, err_q, lim_q, ss;
  logic [STEP_W-1:0] step;
  logic              phase;

  logic             run, wrap, live;
  logic [CNT_W-1:0] floor_v, thr;

  assign run     = en & ~fault;
  assign wrap    = (cnt == TOP);
  assign floor_v = ~lim_q;
  assign thr     = (err_q > ss) ? err_q : ss;
  assign live    = (cnt > thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      err_q <= TOP;
      lim_q <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrap) begin
        err_q <= err_word;
        lim_q <= dt_limit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= 1'b0;
    else if (wrap && thr != TOP)
      phase <= ~phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss   <= TOP;
      step <= '0;
    end else if (!run) begin
      ss   <= TOP;
      step <= '0;
    end else if (wrap) begin
      if (ss < floor_v) begin
        ss <= floor_v;
      end else if (step == STEP_LAST) begin
        step <= '0;
        if (ss > floor_v) ss <= ss - 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assign drv_a = run & live & phase;
  assign drv_b = run & live & ~phase;
endmodule

// File: rtl/pp_pwm_chk.sv
module pp_pwm_chk #(
  parameter int CNT_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic fault,
  input logic drv_a,
  input logic drv_b
);
  localparam logic [CNT_W:0] TOPW = {1'b0, {CNT_W{1'b1}}};

  logic           run;
  logic [CNT_W:0] wa, wb;
  logic [1:0]     last;

  assign run = en & ~fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa   <= '0;
      wb   <= '0;
      last <= 2'd0;
    end else begin
      wa <= drv_a ? wa + 1'b1 : '0;
      wb <= drv_b ? wb + 1'b1 : '0;
      if (!run)       last <= 2'd0;
      else if (drv_a) last <= 2'd1;
      else if (drv_b) last <= 2'd2;
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(drv_a && drv_b)); // R3
  AST_ALT_A: assert property (@(posedge clk) disable iff (!rst_n) $rose(drv_a) |-> last != 2'd1); // R3
  AST_ALT_B: assert property (@(posedge clk) disable iff (!rst_n) $rose(drv_b) |-> last != 2'd2); // R3
  AST_WIDTH_A: assert property (@(posedge clk) disable iff (!rst_n) drv_a |-> wa < TOPW); // R4
  AST_WIDTH_B: assert property (@(posedge clk) disable iff (!rst_n) drv_b |-> wb < TOPW); // R4
  AST_HALT_OFF: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !drv_a && !drv_b); // R8
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(run) |-> !drv_a && !drv_b); // R6
endmodule

bind pp_pwm_gen pp_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fault(fault), .drv_a(drv_a), .drv_b(drv_b)
);

// File: tb/sim_pp_pwm_gen.sv
module sim_pp_pwm_gen;
  localparam int W = 4;
  localparam int TOP = 15;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fault = 1'b0;
  logic [W-1:0] err = '0, lim = '0;
  logic drv_a, drv_b;

  always #4 clk = ~clk;

  pp_pwm_gen #(.CNT_W(W), .SS_STEP(2)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .fault(fault),
    .err_word(err), .dt_limit(lim), .drv_a(drv_a), .drv_b(drv_b)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  int hi_a, hi_b, ovl, pcount, first_w, last_w, max_w, mono_bad, alt_bad, last_side;
  int run_a = 0, run_b = 0;

  // {error word, limit word, expected high cycles per output over 4 periods}
  localparam int VT [8][3] = '{
    '{0, 15, 30}, '{8, 15, 14}, '{15, 15, 0}, '{0, 7, 14},
    '{12, 10, 6}, '{3, 0, 0},   '{4, 4, 8},   '{14, 15, 2}
  };

  task automatic note(int w, int s);
    if (pcount == 0) first_w = w;
    else begin
      if (w < last_w) mono_bad++;
      if (s == last_side) alt_bad++;
    end
    if (w > max_w) max_w = w;
    last_w = w;
    last_side = s;
    pcount++;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (drv_a && drv_b) ovl++;
    hi_a += drv_a ? 1 : 0;
    hi_b += drv_b ? 1 : 0;
    if (drv_a) run_a++;
    else if (run_a > 0) begin note(run_a, 1); run_a = 0; end
    if (drv_b) run_b++;
    else if (run_b > 0) begin note(run_b, 2); run_b = 0; end
  end

  task automatic clr_mon();
    hi_a = 0; hi_b = 0; ovl = 0; pcount = 0; first_w = -1; last_w = 0;
    max_w = 0; mono_bad = 0; alt_bad = 0; last_side = 0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse_start();
    for (int i = 0; i < 100 && !(drv_a || drv_b); i++) cyc(1);
  endtask

  task automatic wait_pcount(int n);
    for (int i = 0; i < 200 && pcount < n; i++) cyc(1);
  endtask

  task automatic ramp_checks(string req);
    clr_mon();
    cyc(16);
    check({req, " no pulse in first period"}, hi_a + hi_b, 0);
    cyc(560);
    check({req, " first ramp width"}, first_w, 1);
    check({req, " ramp widths nondecreasing"}, mono_bad, 0);
    check({req, " ramp end width"}, last_w, TOP);
  endtask

  initial begin
    clr_mon();
    err = '0; lim = 4'd15;
    cyc(5);
    check("R1 drv_a in reset", int'(drv_a), 0);
    check("R1 drv_b in reset", int'(drv_b), 0);
    rst_n = 1'b1;
    cyc(20);
    check("R1 outputs idle after reset", int'(drv_a | drv_b), 0);

    en = 1'b1;
    ramp_checks("R6");
    check("R3 alternation during ramp", alt_bad, 0);
    check("R3 overlap during ramp", ovl, 0);

    for (int v = 0; v < 8; v++) begin
      err = VT[v][0][W-1:0];
      lim = VT[v][1][W-1:0];
      cyc(640);
      clr_mon();
      cyc(64);
      check($sformatf("R2/R5 vector %0d drv_a", v), hi_a, VT[v][2]);
      check($sformatf("R2/R5 vector %0d drv_b", v), hi_b, VT[v][2]);
      check($sformatf("R3 vector %0d overlap", v), ovl, 0);
    end

    err = '0; lim = 4'd15;
    cyc(640);
    clr_mon();
    cyc(128);
    check("R4 longest pulse", max_w, TOP);
    check("R4 per-output high cycles under half", int'(hi_a < 64), 1);
    check("R3 pulses per 8 periods", pcount, 8);
    check("R3 alternation steady", alt_bad, 0);

    lim = 4'd4;
    cyc(33);
    clr_mon();
    cyc(64);
    check("R7 floor jump drv_a", hi_a, 8);
    check("R7 floor jump drv_b", hi_b, 8);

    lim = 4'd15;
    cyc(640);
    wait_pulse_start();
    cyc(5);
    err = 4'd8;
    begin
      int n0;
      n0 = pcount;
      wait_pcount(n0 + 1);
      check("R10 pulse in progress keeps old width", last_w, 15);
      wait_pcount(n0 + 2);
      check("R10 next pulse uses new word", last_w, 7);
    end

    err = '0;
    cyc(64);
    wait_pulse_start();
    fault = 1'b1;
    #1;
    check("R8 outputs off at once", int'(drv_a | drv_b), 0);
    cyc(1);
    clr_mon();
    cyc(40);
    check("R8 outputs off while fault held", hi_a + hi_b, 0);
    fault = 1'b0;
    ramp_checks("R8");

    en = 1'b0;
    #1;
    check("R9 outputs off at disable", int'(drv_a | drv_b), 0);
    cyc(1);
    clr_mon();
    cyc(40);
    check("R9 outputs off while disabled", hi_a + hi_b, 0);
    en = 1'b1;
    ramp_checks("R9");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule